// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Latched Error Flags

This block is the receive half of an asynchronous serial port. It watches the incoming serial line, clocks it through a synchronizer and oversamples it at sixteen times the bit rate. The oversampling strobe comes from outside the block. A start edge is qualified at the middle of the start bit. Data bits follow, least significant first. An optional parity bit and one or two stop bits close the frame. The finished character then moves from the shift register into a holding buffer that software can only read.

At the moment of that move, the block records in one status byte whether the buffer was still unread (overrun), whether parity disagreed and whether the stop bit was missing. A summary flag collects all three errors. The errors stay set until the status byte is written, by any value, or until the serial enable is dropped. Reading the buffer releases the buffer-full flag.

Top module: `async_rx_unit`

## Requirements
- R1: A low line seen in idle opens a start bit. The line is sampled again on the 8th oversample tick after detection. If it is high there, the start is dropped and no character is produced.
- R2: Data bits are taken least significant first, one every 16 oversample ticks. When the first stop bit is sampled, the character moves into the buffer (`rx_data`) and status bit 1 (buffer full) becomes 1.
- R3: A pulse on `buf_rd` clears status bit 1. The buffer contents stay unchanged.
- R4: If a character completes while status bit 1 is 1 and no read occurs in that cycle, status bit 3 (overrun) is set and the buffer keeps its old character.
- R5: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 selects even and 1 selects odd parity. A mismatch sets status bit 4 at the transfer.
- R6: A first stop bit sampled low sets status bit 5 (framing error) at the transfer.
- R7: Status bit 6 is 1 exactly when at least one of bits 3, 4 and 5 is 1.
- R8: A `sts_wr` pulse clears status bits 3 to 6. If a transfer that raises an error falls in the same cycle, that error is set and not cleared.
- R9: With `ser_en`=0, status bits 0 to 6 read 0 and reception stops. With `rx_en`=0 and `ser_en`=1, no character is received and the existing flags and buffer are kept.
- R10: With `cfg_len7`=1, seven data bits are received and buffer bit 7 reads 0.
- R11: Status bit 7 always reads 1. Bits 0 and 2, which belong to the transmit side, read 0. After reset the status byte is 8'h80 and the buffer is 0.
- R12: If a buffer read and a transfer fall in the same cycle, the new character is loaded, status bit 1 stays 1 and no overrun is flagged.
- R13: With `cfg_stop2`=1, the receiver waits out a second stop bit but does not check its level. A low second stop bit sets no framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| cfg_len7 | input | 1 | 1: 7-bit characters, 0: 8-bit |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| rx_en | input | 1 | Receive enable |
| ser_en | input | 1 | Serial enable; 0 clears all flags |
| buf_rd | input | 1 | One-cycle strobe: buffer is being read |
| sts_wr | input | 1 | One-cycle strobe: status byte is being written |
| rx_data | output | DATA_W | Receive buffer |
| status | output | 8 | Status byte, layout per R2 to R11 |

## Verification
Two pairs of events can fall in the same clock. A buffer read can coincide with the shifter-to-buffer transfer, and a status write can coincide with a transfer that carries an error. The bench first measures the clock offset from frame start to the rise of the buffer-full flag on a reference frame, with the tick phase pinned. It then replays frames of the same length with the strobe placed one clock earlier, so that the strobe is sampled on the transfer edge. The read case passes when the new character is loaded, the buffer-full flag is 1 and there is no overrun. The write case passes when the framing and summary flags survive.

// File: rtl/async_rx_pkg.sv
// Package: shared types and status bit positions for the asynchronous receiver.
// Assumes: status byte is always 8 bits; bit positions below are decoded by software.
package async_rx_pkg;

    // Receive frame state machine
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2
    } rx_state_e;

    // Frame format selection
    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } rx_fmt_t;

    localparam int ST_TX_EMPTY = 0;
    localparam int ST_FULL     = 1;
    localparam int ST_TX_DONE  = 2;
    localparam int ST_OVR      = 3;
    localparam int ST_PAR      = 4;
    localparam int ST_FRM      = 5;
    localparam int ST_SUM      = 6;
    localparam int ST_ONE      = 7;

endpackage

// File: rtl/rx_line_sync.sv
// Module: rx_line_sync
// Brings the asynchronous serial line into the clock domain through a flop chain.
// Assumes: the line idles high, so every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            // single register stage
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b1;
                else        q <= line_in;
            end
            assign line_out = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            // shift the line through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], line_in};
            end
            assign line_out = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rx_frame_fsm.sv
// Module: rx_frame_fsm
// Qualifies the start bit at mid-bit, samples data/parity/stop every OS_RATE ticks,
// and emits a one-cycle transfer pulse with the character and its error verdicts.
// Assumes: tick is a one-cycle strobe at OS_RATE times the bit rate; run=0 aborts a frame.
module rx_frame_fsm
    import async_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              line,
    input  rx_fmt_t           fmt,
    output logic              xfer,
    output logic [DATA_W-1:0] xfer_data,
    output logic              xfer_perr,
    output logic              xfer_ferr
);

    localparam int CNT_W  = $clog2(OS_RATE);
    localparam int BIDX_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0]  CNT_MID    = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [BIDX_W-1:0] FULL_LAST  = BIDX_W'(DATA_W - 1);
    localparam logic [BIDX_W-1:0] SHORT_LAST = BIDX_W'(DATA_W - 2);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIDX_W-1:0] bidx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              ferr_q;
    logic              xfer_q;
    logic [BIDX_W-1:0] bit_last;
    logic              at_bit_end;

    assign bit_last   = fmt.len7 ? SHORT_LAST : FULL_LAST;
    assign at_bit_end = tick && (cnt == CNT_LAST);

    // frame sequencing, bit sampling and transfer pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            pbit   <= 1'b0;
            ferr_q <= 1'b0;
            xfer_q <= 1'b0;
        end else begin
            xfer_q <= 1'b0;
            if (!run) begin
                state <= RX_IDLE;
                cnt   <= '0;
                bidx  <= '0;
            end else if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_MID) begin
                            cnt  <= '0;
                            bidx <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W-1:1]};
                            bidx  <= bidx + 1'b1;
                            if (bidx == bit_last)
                                state <= fmt.par_en ? RX_PAR : RX_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            pbit  <= line;
                            state <= RX_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP1: begin
                        if (cnt == CNT_LAST) begin
                            cnt    <= '0;
                            ferr_q <= ~line;
                            xfer_q <= 1'b1;
                            state  <= fmt.stop2 ? RX_STOP2 : RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP2: begin
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // align short characters down and force the top bit to zero
    always_comb begin
        if (fmt.len7) xfer_data = {1'b0, shreg[DATA_W-1:1]};
        else          xfer_data = shreg;
    end

    // parity verdict: data ones plus parity bit must match the selected sense
    assign xfer_perr = fmt.par_en && ((^xfer_data ^ pbit) != fmt.par_odd);
    assign xfer_ferr = ferr_q;
    assign xfer      = xfer_q;

    p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && state == RX_START && cnt == CNT_MID && line) |=> (state == RX_IDLE && !xfer));

    p_xfer_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer);

    p_stop_counted_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (run && at_bit_end && state == RX_STOP2) |=> (state == RX_IDLE && !xfer));

endmodule

// File: rtl/rx_buf_status.sv
// Module: rx_buf_status
// Holds the receive buffer and the status byte; latches errors on each transfer,
// clears buffer-full on read, clears errors on status write, clears all flags on disable.
// Assumes: xfer, buf_rd and sts_wr are single-cycle strobes.
module rx_buf_status
    import async_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              xfer,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              xfer_perr,
    input  logic              xfer_ferr,
    input  logic              buf_rd,
    input  logic              sts_wr,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status
);

    logic [DATA_W-1:0] buf_q;
    logic full_q, ovr_q, par_q, frm_q, sum_q;
    logic set_ovr, set_par, set_frm, set_any, load;

    assign set_ovr = xfer && full_q && !buf_rd;
    assign set_par = xfer && xfer_perr;
    assign set_frm = xfer && xfer_ferr;
    assign set_any = set_ovr || set_par || set_frm;
    assign load    = xfer && (!full_q || buf_rd);

    // buffer register: loads only when the previous character is gone
    always_ff @(posedge clk) begin
        if (!rst_n)    buf_q <= '0;
        else if (load) buf_q <= xfer_data;
    end

    // flag registers: set by transfer, cleared by read, write or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_en) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            sum_q  <= 1'b0;
        end else begin
            full_q <= xfer || (full_q && !buf_rd);
            ovr_q  <= set_ovr || (ovr_q && !sts_wr);
            par_q  <= set_par || (par_q && !sts_wr);
            frm_q  <= set_frm || (frm_q && !sts_wr);
            sum_q  <= set_any || (sum_q && !sts_wr);
        end
    end

    // assemble the status byte
    always_comb begin
        status              = '0;
        status[ST_TX_EMPTY] = 1'b0;
        status[ST_FULL]     = full_q;
        status[ST_TX_DONE]  = 1'b0;
        status[ST_OVR]      = ovr_q;
        status[ST_PAR]      = par_q;
        status[ST_FRM]      = frm_q;
        status[ST_SUM]      = sum_q;
        status[ST_ONE]      = 1'b1;
    end

    assign rx_data = buf_q;

    p_full_on_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && ser_en) |=> status[ST_FULL]);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !xfer && ser_en) |=> (!status[ST_FULL] && $stable(rx_data)));

    p_overrun_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && ser_en && status[ST_FULL] && !buf_rd) |=> (status[ST_OVR] && $stable(rx_data)));

    p_summary_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_SUM] == (status[ST_OVR] || status[ST_PAR] || status[ST_FRM]));

    p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !xfer && ser_en) |=> (status[6:3] == 4'b0000));

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en) |=> (status[6:0] == 7'b0));

    p_same_cycle_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && ser_en && buf_rd && !status[ST_OVR]) |=> (status[ST_FULL] && !status[ST_OVR]));

endmodule

// File: rtl/async_rx_unit.sv
// Module: async_rx_unit (top)
// Asynchronous serial receiver: line synchronizer, frame sampler and buffer/status.
// Assumes: os_tick is supplied externally at 16x the bit rate; strobes last one cycle.
module async_rx_unit
    import async_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              cfg_len7,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              rx_en,
    input  logic              ser_en,
    input  logic              buf_rd,
    input  logic              sts_wr,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status
);

    logic              line_s;
    logic              run;
    logic              xfer;
    logic [DATA_W-1:0] xfer_data;
    logic              xfer_perr;
    logic              xfer_ferr;
    rx_fmt_t           fmt;

    assign run = rx_en && ser_en;

    // gather format bits into the shared struct
    always_comb begin
        fmt.len7    = cfg_len7;
        fmt.par_en  = cfg_par_en;
        fmt.par_odd = cfg_par_odd;
        fmt.stop2   = cfg_stop2;
    end

    rx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rxd),
        .line_out (line_s)
    );

    rx_frame_fsm #(
        .DATA_W  (DATA_W),
        .OS_RATE (OS_RATE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (os_tick),
        .line      (line_s),
        .fmt       (fmt),
        .xfer      (xfer),
        .xfer_data (xfer_data),
        .xfer_perr (xfer_perr),
        .xfer_ferr (xfer_ferr)
    );

    rx_buf_status #(
        .DATA_W (DATA_W)
    ) u_bs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_en    (ser_en),
        .xfer      (xfer),
        .xfer_data (xfer_data),
        .xfer_perr (xfer_perr),
        .xfer_ferr (xfer_ferr),
        .buf_rd    (buf_rd),
        .sts_wr    (sts_wr),
        .rx_data   (rx_data),
        .status    (status)
    );

endmodule

// File: tb/test_async_rx_unit.sv
`timescale 1ns/1ps
// Directed bench for async_rx_unit: one task per scenario, each checking its own results.
module test_async_rx_unit;

    localparam int BITCLK = 32;   // 16 ticks per bit, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic os_tick = 1'b0;
    logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic rx_en = 1'b1, ser_en = 1'b1;
    logic buf_rd = 1'b0, sts_wr = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] status;

    int checks = 0;
    int fails = 0;
    bit ph = 1'b0;
    int rise_at = -1;
    int cal_k = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    async_rx_unit i_async_rx_unit (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rx_en(rx_en), .ser_en(ser_en),
        .buf_rd(buf_rd), .sts_wr(sts_wr), .rx_data(rx_data), .status(status)
    );

    // one clock step at the falling edge, advancing the tick phase
    task automatic clk1();
        @(negedge clk);
        ph = ~ph;
        os_tick = ph;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) clk1();
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 read strobe, 2 status-write strobe, at clock index "at"
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_low,
                              input bit stop2_low, input int kind, input int at);
        logic bits [0:11];
        int nb;
        int nd;
        logic p;
        bit seen;
        nd = cfg_len7 ? 7 : 8;
        nb = 0;
        bits[nb] = 1'b0; nb++;
        p = cfg_par_odd;
        for (int i = 0; i < nd; i++) begin
            bits[nb] = d[i]; nb++;
            p = p ^ d[i];
        end
        if (cfg_par_en) begin bits[nb] = p ^ bad_par; nb++; end
        bits[nb] = ~stop_low; nb++;
        if (cfg_stop2) begin bits[nb] = ~stop2_low; nb++; end
        if (ph) clk1();
        seen = status[1];
        rise_at = -1;
        for (int c = 0; c < nb * BITCLK; c++) begin
            clk1();
            if (!seen && status[1]) begin seen = 1'b1; rise_at = c; end
            rxd = bits[c / BITCLK];
            buf_rd = (kind == 1) && (c == at);
            sts_wr = (kind == 2) && (c == at);
        end
        clk1();
        buf_rd = 1'b0; sts_wr = 1'b0; rxd = 1'b1;
        idle(40);
    endtask

    task automatic pulse_read();
        clk1(); buf_rd = 1'b1; clk1(); buf_rd = 1'b0; clk1();
    endtask

    task automatic pulse_write();
        clk1(); sts_wr = 1'b1; clk1(); sts_wr = 1'b0; clk1();
    endtask

    task automatic t_reset();
        chk("R11 reset status", status, 8'h80);
        chk("R11 reset buffer", rx_data, 8'h00);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 0, 0, 0, 0, -1);
        chk("R2 full after frame", status, 8'h82);
        chk("R2 data lsb first", rx_data, 8'hA5);
        pulse_read();
        chk("R3 read clears full", status, 8'h80);
        chk("R3 data kept on read", rx_data, 8'hA5);
        send_frame(8'h3C, 0, 0, 0, 0, -1);
        chk("R2 second pattern", rx_data, 8'h3C);
        pulse_read();
    endtask

    task automatic t_len7();
        cfg_len7 = 1'b1;
        send_frame(8'hD3, 0, 0, 0, 0, -1);
        chk("R10 seven-bit data msb zero", rx_data, 8'h53);
        pulse_read();
        cfg_len7 = 1'b0;
    endtask

    task automatic t_parity();
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_frame(8'h3B, 0, 0, 0, 0, -1);
        chk("R5 even parity good", status, 8'h82);
        pulse_read();
        send_frame(8'h3B, 1, 0, 0, 0, -1);
        chk("R5 R7 even parity bad", status, 8'hD2);
        chk("R5 data with parity", rx_data, 8'h3B);
        pulse_read(); pulse_write();
        chk("R8 write clears parity", status, 8'h80);
        cfg_par_odd = 1'b1;
        send_frame(8'h96, 0, 0, 0, 0, -1);
        chk("R5 odd parity good", status, 8'h82);
        pulse_read();
        send_frame(8'h96, 1, 0, 0, 0, -1);
        chk("R5 odd parity bad", status, 8'hD2);
        pulse_read(); pulse_write();
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h0F, 0, 1, 0, 0, -1);
        chk("R6 R7 framing error", status, 8'hE2);
        pulse_write();
        chk("R8 write clears framing", status, 8'h82);
        pulse_read();
    endtask

    task automatic t_overrun_disable();
        send_frame(8'h11, 0, 0, 0, 0, -1);
        send_frame(8'h22, 0, 0, 0, 0, -1);
        chk("R4 R7 overrun flagged", status, 8'hCA);
        chk("R4 old data kept", rx_data, 8'h11);
        rx_en = 1'b0;
        send_frame(8'h77, 0, 1, 0, 0, -1);
        chk("R9 rx disabled keeps flags", status, 8'hCA);
        chk("R9 rx disabled keeps data", rx_data, 8'h11);
        rx_en = 1'b1;
        clk1(); ser_en = 1'b0; idle(3);
        chk("R9 serial disable clears flags", status, 8'h80);
        send_frame(8'h66, 0, 0, 0, 0, -1);
        chk("R9 no reception while disabled", status, 8'h80);
        ser_en = 1'b1; idle(3);
    endtask

    task automatic t_false_start();
        if (ph) clk1();
        rxd = 1'b0; idle(6);
        rxd = 1'b1; idle(60);
        chk("R1 short low dropped", status, 8'h80);
        send_frame(8'h5A, 0, 0, 0, 0, -1);
        chk("R1 recovers after glitch", rx_data, 8'h5A);
        pulse_read();
    endtask

    task automatic t_stop2();
        cfg_stop2 = 1'b1;
        send_frame(8'hC3, 0, 0, 1, 0, -1);
        chk("R13 second stop unchecked", status, 8'h82);
        chk("R13 data with two stops", rx_data, 8'hC3);
        pulse_read();
        cfg_stop2 = 1'b0;
        idle(40);
    endtask

    task automatic t_coincide();
        send_frame(8'h33, 0, 0, 0, 0, -1);
        cal_k = rise_at;
        pulse_read();
        send_frame(8'h44, 0, 0, 0, 0, -1);
        send_frame(8'h55, 0, 0, 0, 1, cal_k - 1);
        chk("R12 read with transfer status", status, 8'h82);
        chk("R12 read with transfer data", rx_data, 8'h55);
        pulse_read();
        send_frame(8'h0A, 0, 1, 0, 2, cal_k - 1);
        chk("R8 write with error transfer", status, 8'hE2);
        pulse_read(); pulse_write();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(6);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_basic();
        t_len7();
        t_parity();
        t_framing();
        t_overrun_disable();
        t_false_start();
        t_stop2();
        t_coincide();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule